// File: doc/BRIEF.md
# Floating-Point Register Stack File

This block keeps eight 80-bit extended-precision values. Each value has a 1-bit sign, a 15-bit exponent and a 64-bit significand whose leading bit is stored explicitly, with no hidden bit. Software sees the entries as a stack. The stack is addressed relative to a rotating top pointer, so slot ST(i) is physical register (TOP + i) mod 8.

A single command port carries an opcode, a relative index and an 80-bit data word. The commands load a new value onto the stack, remove and return the top value, read any ST(i), overwrite any ST(i) in place, and exchange ST(0) with ST(i). A further command clears the whole stack.

Each register carries a 2-bit tag that marks it empty or valid. The tags drive fault detection:
- A push into a slot that is still valid is an overflow. The contents are not spilled anywhere.
- Any access that needs an empty slot to hold data is an underflow.

Both faults leave the stack untouched and are reported on one-cycle exception outputs. Handling them is left to the arithmetic unit and its software.

Top module: `fp_regstack`

## Requirements
- R1: Reset and the clear command (opcode 6) set TOP to 0 and tag every register empty. Afterwards any read or pop of ST(0) faults as underflow.
- R2: A push (opcode 1) into an empty slot first moves TOP to (TOP - 1) mod 8, then stores the data there, so the pushed value becomes ST(0).
- R3: A push whose target slot (TOP - 1) mod 8 is already valid raises `ovf_err` for one cycle. TOP and every stored value and tag stay unchanged.
- R4: A pop (opcode 2) of a valid ST(0) returns that value with `rsp_valid` high, tags the slot empty and moves TOP to (TOP + 1) mod 8.
- R5: A pop or a read (opcode 4) of an empty slot raises `unf_err` and gives no response. TOP and the contents stay unchanged.
- R6: A read of ST(i) returns physical register (TOP + i) mod 8, which is the value pushed i pushes before the most recent one still on the stack.
- R7: A write (opcode 3) replaces the value of a valid ST(i) and leaves TOP unchanged. A write to an empty ST(i) raises `unf_err` and changes nothing.
- R8: An exchange (opcode 5) swaps ST(0) and ST(i) in one command. If either slot is empty it raises `unf_err` and changes nothing.
- R9: Values travel bit-exact across all 80 bits: sign in bit 79, exponent in bits 78:64, significand in bits 63:0.
- R10: Every output is registered and shows the result of a command accepted at a clock edge right after that edge. `rsp_data` is zero whenever `rsp_valid` is low, the two faults never occur together, and opcode 0 (no operation) changes nothing.
- R11: While `cmd_valid` is low the opcode, index and data are ignored: TOP and the contents hold, and no response or fault appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 nop, 1 push, 2 pop, 3 write, 4 read, 5 exchange, 6 clear |
| cmd_idx | input | 3 | Relative index i of ST(i) |
| cmd_data | input | 80 | Value for push and write |
| rsp_valid | output | 1 | Response data valid (pop, read) |
| rsp_data | output | 80 | Returned value, zero when no response |
| top_ptr | output | 3 | Current physical top-of-stack index |
| ovf_err | output | 1 | Stack overflow fault, one-cycle pulse |
| unf_err | output | 1 | Stack underflow fault, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: eight entries and a 1/15/64 field split.

With eight entries, a short run of pushes fills every slot. That brings the following cases within reach:
- the overflow fault on the ninth push;
- TOP wrapping from 0 to 7 and back;
- reads of every ST(i) through the full modular index range.

After partial pops, the same depth leaves holes. These let the bench drive writes and exchanges that must fault because they name an empty slot.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4,
    OP_XCHG  = 3'd5,
    OP_CLEAR = 3'd6
  } op_t;

  typedef enum logic [1:0] {
    TAG_VALID = 2'b00,
    TAG_EMPTY = 2'b11
  } tag_t;

endpackage

// File: rtl/fprs_tags.sv
module fprs_tags
  import fprs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             set_en,
  input  logic [PTR_W-1:0] set_addr,
  input  logic             clr_en,
  input  logic [PTR_W-1:0] clr_addr,
  output logic [DEPTH-1:0] valid_o
);

  tag_t tag_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst || clr_all)
        tag_q[g] <= TAG_EMPTY;
      else if (set_en && set_addr == PTR_W'(g))
        tag_q[g] <= TAG_VALID;
      else if (clr_en && clr_addr == PTR_W'(g))
        tag_q[g] <= TAG_EMPTY;
    end
    assign valid_o[g] = (tag_q[g] == TAG_VALID);
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (valid_o == '0));  // R1

  AST_SET_CLR_APART: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en && set_addr == clr_addr));  // R4

endmodule

// File: rtl/fprs_regs.sv
module fprs_regs #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_en,
  input  logic [PTR_W-1:0]  wa_addr,
  input  logic [WORD_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [PTR_W-1:0]  wb_addr,
  input  logic [WORD_W-1:0] wb_data,
  input  logic [PTR_W-1:0]  ra_addr,
  output logic [WORD_W-1:0] ra_data,
  input  logic [PTR_W-1:0]  rb_addr,
  output logic [WORD_W-1:0] rb_data
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wa_en && wa_addr == PTR_W'(g))
        mem_q[g] <= wa_data;
      else if (wb_en && wb_addr == PTR_W'(g))
        mem_q[g] <= wb_data;
    end
  end

  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];

  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en) |-> (wa_addr != wb_addr));  // R8

endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
  import fprs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SIGN_W = 1,
  parameter int EXP_W  = 15,
  parameter int MAN_W  = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int WORD_W = SIGN_W + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [PTR_W-1:0]  top_ptr,
  output logic              ovf_err,
  output logic              unf_err
);

  op_t               op;
  logic [PTR_W-1:0]  top_d, phys_i, push_slot;
  logic [DEPTH-1:0]  tag_valid;
  logic [WORD_W-1:0] st0_data, sti_data;
  logic              wa_en, wb_en, set_en, clr_en, clr_all;
  logic [PTR_W-1:0]  wa_addr, wb_addr, set_addr, clr_addr;
  logic [WORD_W-1:0] wa_data, wb_data, rsp_d;
  logic              rsp_v_d, ovf_d, unf_d;

  assign op        = op_t'(cmd_op);
  assign phys_i    = top_ptr + cmd_idx;
  assign push_slot = top_ptr - 1'b1;

  fprs_regs #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_data),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_data (wb_data),
    .ra_addr (top_ptr),
    .ra_data (st0_data),
    .rb_addr (phys_i),
    .rb_data (sti_data)
  );

  fprs_tags #(.DEPTH(DEPTH)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (clr_all),
    .set_en   (set_en),
    .set_addr (set_addr),
    .clr_en   (clr_en),
    .clr_addr (clr_addr),
    .valid_o  (tag_valid)
  );

  always_comb begin
    top_d    = top_ptr;
    wa_en    = 1'b0;
    wa_addr  = top_ptr;
    wa_data  = cmd_data;
    wb_en    = 1'b0;
    wb_addr  = phys_i;
    wb_data  = st0_data;
    set_en   = 1'b0;
    set_addr = push_slot;
    clr_en   = 1'b0;
    clr_addr = top_ptr;
    clr_all  = 1'b0;
    rsp_v_d  = 1'b0;
    rsp_d    = '0;
    ovf_d    = 1'b0;
    unf_d    = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_PUSH: begin
          if (tag_valid[push_slot]) begin
            ovf_d = 1'b1;
          end else begin
            top_d   = push_slot;
            wa_en   = 1'b1;
            wa_addr = push_slot;
            set_en  = 1'b1;
          end
        end
        OP_POP: begin
          if (!tag_valid[top_ptr]) begin
            unf_d = 1'b1;
          end else begin
            rsp_v_d = 1'b1;
            rsp_d   = st0_data;
            clr_en  = 1'b1;
            top_d   = top_ptr + 1'b1;
          end
        end
        OP_READ: begin
          if (!tag_valid[phys_i]) begin
            unf_d = 1'b1;
          end else begin
            rsp_v_d = 1'b1;
            rsp_d   = sti_data;
          end
        end
        OP_WRITE: begin
          if (!tag_valid[phys_i]) begin
            unf_d = 1'b1;
          end else begin
            wa_en   = 1'b1;
            wa_addr = phys_i;
          end
        end
        OP_XCHG: begin
          if (!tag_valid[top_ptr] || !tag_valid[phys_i]) begin
            unf_d = 1'b1;
          end else if (cmd_idx != '0) begin
            wa_en   = 1'b1;
            wa_addr = top_ptr;
            wa_data = sti_data;
            wb_en   = 1'b1;
          end
        end
        OP_CLEAR: begin
          clr_all = 1'b1;
          top_d   = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_ptr   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      ovf_err   <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      top_ptr   <= top_d;
      rsp_valid <= rsp_v_d;
      rsp_data  <= rsp_d;
      ovf_err   <= ovf_d;
      unf_err   <= unf_d;
    end
  end

  AST_OVF_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> $stable(top_ptr));  // R3

  AST_PUSH_MOVES_TOP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_PUSH && !tag_valid[push_slot])
      |=> (top_ptr == PTR_W'($past(top_ptr) - 1'b1)));  // R2

  AST_POP_MOVES_TOP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_POP && tag_valid[top_ptr])
      |=> (rsp_valid && top_ptr == PTR_W'($past(top_ptr) + 1'b1)));  // R4

  AST_UNF_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    unf_err |-> (!rsp_valid && rsp_data == '0));  // R5

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
    !(ovf_err && unf_err));  // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(top_ptr) && !rsp_valid && !ovf_err && !unf_err));  // R11

endmodule

// File: tb/sim_fp_regstack.sv
module sim_fp_regstack;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct {
    bit          v;
    logic [79:0] d;
    bit          o;
    bit          u;
    logic [2:0]  t;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_idx = 3'd0;
  logic [79:0] cmd_data = '0;
  logic        rsp_valid;
  logic [79:0] rsp_data;
  logic [2:0]  top_ptr;
  logic        ovf_err, unf_err;

  exp_t        exp_q [$];
  exp_t        e;
  int          nvec = 0;
  int          nerr = 0;
  bit          done = 1'b0;

  logic [79:0] mdl [8];
  bit          mval [8];
  logic [2:0]  mtop = 3'd0;

  always #2.5 clk = ~clk;

  fp_regstack u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .top_ptr(top_ptr), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  function automatic logic [79:0] mk(int k);
    logic [63:0] m;
    m = 64'h8000_0000_0000_0000 | 64'(k * 32'h9E37_79B9);
    return {k[0], 15'(16'h3FFF + k), m};
  endfunction

  task automatic drive(bit vld, logic [2:0] op, logic [2:0] idx, logic [79:0] d, string req);
    exp_t x;
    logic [2:0] p, s;
    logic [79:0] tmp;
    @(negedge clk);
    cmd_valid = vld; cmd_op = op; cmd_idx = idx; cmd_data = d;
    x.v = 0; x.d = '0; x.o = 0; x.u = 0; x.req = req;
    p = mtop + idx;
    if (vld) begin
      case (op)
        3'd1: begin
          s = mtop - 3'd1;
          if (mval[s]) x.o = 1;
          else begin mdl[s] = d; mval[s] = 1; mtop = s; end
        end
        3'd2: begin
          if (!mval[mtop]) x.u = 1;
          else begin x.v = 1; x.d = mdl[mtop]; mval[mtop] = 0; mtop = mtop + 3'd1; end
        end
        3'd3: if (!mval[p]) x.u = 1; else mdl[p] = d;
        3'd4: if (!mval[p]) x.u = 1; else begin x.v = 1; x.d = mdl[p]; end
        3'd5: begin
          if (!mval[mtop] || !mval[p]) x.u = 1;
          else begin tmp = mdl[mtop]; mdl[mtop] = mdl[p]; mdl[p] = tmp; end
        end
        3'd6: begin mtop = 0; for (int i = 0; i < 8; i++) mval[i] = 0; end
        default: ;
      endcase
    end
    x.t = mtop;
    exp_q.push_back(x);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit bad;
      e = exp_q.pop_front();
      nvec++;
      bad = 0;
      if (rsp_valid !== e.v) begin bad = 1; $display("FAIL %s rsp_valid act=%0b exp=%0b", e.req, rsp_valid, e.v); end
      if (rsp_data !== e.d) begin bad = 1; $display("FAIL %s rsp_data act=%h exp=%h", e.req, rsp_data, e.d); end
      if (ovf_err !== e.o) begin bad = 1; $display("FAIL %s ovf_err act=%0b exp=%0b", e.req, ovf_err, e.o); end
      if (unf_err !== e.u) begin bad = 1; $display("FAIL %s unf_err act=%0b exp=%0b", e.req, unf_err, e.u); end
      if (top_ptr !== e.t) begin bad = 1; $display("FAIL %s top_ptr act=%0d exp=%0d", e.req, top_ptr, e.t); end
      if (bad) nerr++;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mval[i] = 0; mdl[i] = '0; end
    repeat (3) @(negedge clk);
    nvec++;  // R1 reset state
    if (top_ptr !== 3'd0 || rsp_valid !== 1'b0 || ovf_err !== 1'b0 || unf_err !== 1'b0) begin
      nerr++;
      $display("FAIL R1 reset top=%0d rv=%0b ov=%0b un=%0b exp=0 0 0 0", top_ptr, rsp_valid, ovf_err, unf_err);
    end
    rst = 1'b0;
    drive(1, 3'd4, 3'd0, '0, "R1");          // read ST0 of empty stack
    drive(1, 3'd2, 3'd0, '0, "R5");          // pop empty
    for (int k = 1; k <= 8; k++) drive(1, 3'd1, 3'd0, mk(k), "R2");
    drive(1, 3'd1, 3'd0, mk(99), "R3");      // overflow
    for (int i = 0; i < 8; i++) drive(1, 3'd4, 3'(i), '0, "R6");
    drive(1, 3'd0, 3'd0, '0, "R10");         // nop
    drive(1, 3'd3, 3'd3, mk(40), "R7");
    drive(1, 3'd4, 3'd3, '0, "R7");
    drive(1, 3'd5, 3'd5, '0, "R8");
    drive(1, 3'd4, 3'd0, '0, "R8");
    drive(1, 3'd4, 3'd5, '0, "R8");
    drive(1, 3'd5, 3'd0, '0, "R8");          // self exchange
    drive(1, 3'd4, 3'd0, '0, "R9");
    for (int k = 0; k < 3; k++) drive(1, 3'd2, 3'd0, '0, "R4");
    drive(1, 3'd4, 3'd7, '0, "R5");          // read of popped slot
    drive(1, 3'd3, 3'd6, mk(50), "R7");      // write to empty slot
    drive(1, 3'd4, 3'd6, '0, "R7");
    drive(1, 3'd5, 3'd7, '0, "R8");          // exchange with empty slot
    drive(0, 3'd1, 3'd0, mk(60), "R11");     // ignored push
    drive(0, 3'd2, 3'd0, '0, "R11");         // ignored pop
    drive(1, 3'd4, 3'd0, '0, "R11");
    drive(1, 3'd6, 3'd0, '0, "R1");          // clear
    drive(1, 3'd2, 3'd0, '0, "R1");
    drive(1, 3'd1, 3'd0, mk(70), "R2");      // wrap 0 -> 7
    drive(1, 3'd1, 3'd0, {1'b1, 15'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF}, "R9");
    drive(1, 3'd2, 3'd0, '0, "R9");
    drive(1, 3'd2, 3'd0, '0, "R4");          // top wraps 7 -> 0
    drive(1, 3'd2, 3'd0, '0, "R5");
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule